// File: doc/BRIEF.md
# Dual-Standard Bipolar Line Decoder

This block sits on the receive side of a T1/E1 line interface. It sits behind clock and data recovery. On every rising edge of the receive clock it samples a positive rail and a negative rail. From them it rebuilds the NRZ bit stream. It also checks the stream for line-code errors.

In E1 mode it strips HDB3 zero substitutions, and in T1 mode it strips B8ZS substitutions. When substitution decoding is switched off it treats the line as plain AMI. It flags bipolar violations, code violations, excessive-zero runs and bits with both rails high.

In NRZ mode the decoded data leaves on the positive output, and a one-bit error pulse leaves on the negative output. In bipolar mode both rails are forwarded unchanged. Every mode uses the same fixed delay of eight bit periods. A control input selects whether the outputs change on the rising or the falling clock edge.

Top module: `bpd_line_decoder`

## Requirements
- R1: During reset, and when reset ends, both outputs are 0. Pulse and violation history is also cleared, so the first pulse after reset is never a violation.
- R2: With `fall_edge`=0, a bit sampled at rising edge k appears at the outputs just after rising edge k+8. The outputs stay stable until the next rising edge.
- R3: With `fall_edge`=1, the outputs change on the falling edge that comes half a period before rising edge k+8. The value is the same as in R2.
- R4: With `nrz_mode`=0, `pos_out` and `neg_out` repeat `pos_in` and `neg_in` unchanged, including violations and substitutions.
- R5: With `nrz_mode`=1, `pos_out` carries the decoded bit (1 = a pulse was received and not absorbed). `neg_out` is 1 for exactly the bit periods that hold an error. Several errors on one bit still give a single 1.
- R6: In HDB3 mode (`t1_mode`=0, `sub_off`=0), a violation whose two preceding bit periods held no pulse is taken as a substitution. The violation decodes as 0 and raises no bipolar error. A pulse three positions before it is treated as a balancing pulse and also decodes as 0.
- R7: In HDB3 mode, a violation with the same polarity as the previous violation is a code violation and is flagged, even if R6 absorbs it.
- R8: In B8ZS mode (`t1_mode`=1, `sub_off`=0), the sequence 0,0,0,V,B,0,V,B decodes as eight zeros with no error. Here V is a violation and B is a pulse of alternating polarity.
- R9: A pulse with the same polarity as the previous pulse is a violation. A violation that is not absorbed decodes as 1 and is flagged. Polarity encoding: `pos_in`=1 is a positive pulse, and `neg_in`=1 alone is a negative pulse.
- R10: A bit with both rails high is taken as a positive pulse and flagged.
- R11: Excessive zeros are flagged once per run, on the 4th consecutive empty bit in E1 mode and on the 8th in T1 mode. A shorter run is not flagged.
- R12: With `sub_off`=1 the line is plain AMI. Nothing is absorbed, so every violation is flagged under R9, including those shaped like R6 or R8 patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_in | input | 1 | Positive rail pulse for this bit |
| neg_in | input | 1 | Negative rail pulse for this bit |
| t1_mode | input | 1 | 1 = T1 (B8ZS, 8-zero limit), 0 = E1 (HDB3, 4-zero limit) |
| sub_off | input | 1 | 1 = no substitution decoding (plain AMI) |
| nrz_mode | input | 1 | 1 = NRZ data plus error pulse, 0 = rails passed through |
| fall_edge | input | 1 | 1 = outputs change on the falling clock edge |
| pos_out | output | 1 | Decoded data or positive rail |
| neg_out | output | 1 | Error pulse or negative rail |

## Verification
Every result is due a fixed eight rising edges after the edge that sampled its bit. The driver stamps each expected item with that edge number. The monitor compares an item a quarter period after its due edge, so the same sample point serves both edge settings. A second probe, just before the next rising edge, makes two checks. In falling-edge mode it checks that the next item is already visible. In rising-edge mode it checks that the current item is still held.

// File: rtl/bpd_pkg.sv
// Shared types for the bipolar line decoder.
// One bpd_slot_t travels down the decode delay line per received bit.
package bpd_pkg;

    typedef struct packed {
        logic raw_p;   // positive rail as received
        logic raw_n;   // negative rail as received
        logic mark;    // decoded data bit after substitution removal
        logic viol;    // pulse had the same polarity as the pulse before it
        logic err;     // bit carries an error to report
    } bpd_slot_t;

    localparam int unsigned E1_ZLIM = 4;  // zero-run limit in E1 modes
    localparam int unsigned T1_ZLIM = 8;  // zero-run limit in T1 modes

endpackage

// File: rtl/bpd_classify.sv
// Per-bit line classifier.
// Looks at the incoming rails and at the pulse history, and reports for the
// current bit: pulse present, bipolar violation, HDB3 code violation,
// excessive-zero event and dual-rail fault.
// Assumes: one bit per rising clk edge; both rails high counts as positive.
module bpd_classify #(
    parameter int ZW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_in,
    input  logic neg_in,
    input  logic t1_mode,
    input  logic sub_off,
    output logic c_pulse,
    output logic c_viol,
    output logic c_cv,
    output logic c_exz,
    output logic c_dual
);
    import bpd_pkg::*;

    logic          last_pol;
    logic          seen_pulse;
    logic          last_vpol;
    logic          seen_viol;
    logic [ZW-1:0] zrun;
    logic [ZW-1:0] zlim;
    logic          pol;

    // Classify the current bit against the stored history.
    always_comb begin
        zlim    = t1_mode ? ZW'(T1_ZLIM) : ZW'(E1_ZLIM);
        pol     = pos_in;
        c_pulse = pos_in | neg_in;
        c_dual  = pos_in & neg_in;
        c_viol  = c_pulse && seen_pulse && (pol == last_pol);
        c_cv    = c_viol && !t1_mode && !sub_off && seen_viol && (pol == last_vpol);
        c_exz   = !c_pulse && (zrun == zlim - ZW'(1));
    end

    // Track the last pulse polarity, the last violation polarity and the zero run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pol   <= 1'b0;
            seen_pulse <= 1'b0;
            last_vpol  <= 1'b0;
            seen_viol  <= 1'b0;
            zrun       <= '0;
        end else if (c_pulse) begin
            last_pol   <= pol;
            seen_pulse <= 1'b1;
            zrun       <= '0;
            if (c_viol) begin
                last_vpol <= pol;
                seen_viol <= 1'b1;
            end
        end else if (zrun < zlim) begin
            zrun <= zrun + ZW'(1);
        end
    end

    AST_EXZ_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) c_exz |-> ($past(pos_in) == 1'b0 && $past(neg_in) == 1'b0)); // R11

endmodule

// File: rtl/bpd_window.sv
// Substitution window and delay line.
// Holds the last DEPTH classified bits. It removes HDB3 substitutions as the
// violation arrives, and removes B8ZS substitutions when the closing pulse
// arrives. Errors travel with each bit and are cleared when the bit is absorbed.
// Assumes DEPTH >= 7 so that a whole B8ZS pattern fits inside the line.
module bpd_window #(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                t1_mode,
    input  logic                sub_off,
    input  logic                pos_in,
    input  logic                neg_in,
    input  logic                c_pulse,
    input  logic                c_viol,
    input  logic                c_cv,
    input  logic                c_exz,
    input  logic                c_dual,
    output bpd_pkg::bpd_slot_t  tail
);
    import bpd_pkg::*;

    localparam int B8_SPAN = 7;

    bpd_slot_t [DEPTH-1:0] d_q;
    bpd_slot_t [DEPTH-1:0] mod;
    bpd_slot_t             head;
    logic hdb3_on, b8zs_on, h_abs, b_hit, gap_ok;

    function automatic logic anyp(input bpd_slot_t s);
        return s.raw_p | s.raw_n;
    endfunction

    // Check that the three oldest pattern slots are empty.
    always_comb begin
        gap_ok = 1'b1;
        for (int i = 4; i < B8_SPAN; i++) begin
            if (anyp(d_q[i])) gap_ok = 1'b0;
        end
    end

    // Recognise the substitution patterns that end with the current bit.
    always_comb begin
        hdb3_on = !t1_mode && !sub_off;
        b8zs_on = t1_mode && !sub_off;
        h_abs   = hdb3_on && c_viol && !anyp(d_q[0]) && !anyp(d_q[1]);
        b_hit   = b8zs_on && c_pulse && !c_viol && d_q[0].viol && !anyp(d_q[1])
                  && anyp(d_q[2]) && !d_q[2].viol && d_q[3].viol && gap_ok;
    end

    // Build the new slot and clear the absorbed pulses already in the line.
    always_comb begin
        head.raw_p = pos_in;
        head.raw_n = neg_in;
        head.mark  = c_pulse && !h_abs && !b_hit;
        head.viol  = c_viol;
        head.err   = !b_hit && ((c_viol && !h_abs) || c_cv || c_exz || c_dual);
        mod = d_q;
        if (h_abs) mod[2].mark = 1'b0;
        if (b_hit) begin
            mod[0].mark = 1'b0; mod[0].err = 1'b0; mod[0].viol = 1'b0;
            mod[2].mark = 1'b0; mod[2].err = 1'b0;
            mod[3].mark = 1'b0; mod[3].err = 1'b0; mod[3].viol = 1'b0;
        end
    end

    // Shift the delay line by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= {mod[DEPTH-2:0], head};
    end

    assign tail = d_q[DEPTH-1];

    AST_HDB3_ABSORB_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (h_abs && !c_cv && !c_dual) |=> (!d_q[0].mark && !d_q[0].err)); // R6
    AST_B8ZS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n) b_hit |=> (!d_q[0].mark && !d_q[1].mark && !d_q[3].mark && !d_q[4].mark && !d_q[1].err && !d_q[3].err && !d_q[4].err)); // R8
    AST_AMI_VIOL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (sub_off && c_viol) |=> d_q[0].err); // R12

endmodule

// File: rtl/bpd_outstage.sv
// Output stage.
// Chooses NRZ data plus error, or the raw rails. Registers the result on both
// clock edges and presents the copy picked by fall_edge.
// Assumes fall_edge changes only while the line is idle or in reset.
module bpd_outstage (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_mode,
    input  logic fall_edge,
    input  logic t_raw_p,
    input  logic t_raw_n,
    input  logic t_mark,
    input  logic t_err,
    output logic pos_out,
    output logic neg_out
);
    logic sel_p, sel_n;
    logic rise_p, rise_n, fall_p, fall_n;

    // Pick the output pair for the current mode.
    always_comb begin
        sel_p = nrz_mode ? t_mark : t_raw_p;
        sel_n = nrz_mode ? t_err  : t_raw_n;
    end

    // Rising-edge output copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_p <= 1'b0;
            rise_n <= 1'b0;
        end else begin
            rise_p <= sel_p;
            rise_n <= sel_n;
        end
    end

    // Falling-edge output copy.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fall_p <= 1'b0;
            fall_n <= 1'b0;
        end else begin
            fall_p <= sel_p;
            fall_n <= sel_n;
        end
    end

    assign pos_out = fall_edge ? fall_p : rise_p;
    assign neg_out = fall_edge ? fall_n : rise_n;

    AST_BIPOLAR_RAW: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && !$past(nrz_mode)) |-> (rise_p == $past(t_raw_p) && rise_n == $past(t_raw_n))); // R4

endmodule

// File: rtl/bpd_line_decoder.sv
// Dual-standard bipolar line decoder, top level.
// Connects the classifier, the substitution window and the output stage.
// The total delay is DEPTH bit periods, plus the output register.
// Assumes one received bit per rising edge of clk.
module bpd_line_decoder #(
    parameter int DEPTH = 8,
    parameter int ZW    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_in,
    input  logic neg_in,
    input  logic t1_mode,
    input  logic sub_off,
    input  logic nrz_mode,
    input  logic fall_edge,
    output logic pos_out,
    output logic neg_out
);
    import bpd_pkg::*;

    logic c_pulse, c_viol, c_cv, c_exz, c_dual;
    bpd_slot_t tail;

    bpd_classify #(.ZW(ZW)) u_cls (
        .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .neg_in(neg_in),
        .t1_mode(t1_mode), .sub_off(sub_off),
        .c_pulse(c_pulse), .c_viol(c_viol), .c_cv(c_cv), .c_exz(c_exz), .c_dual(c_dual)
    );

    bpd_window #(.DEPTH(DEPTH)) u_win (
        .clk(clk), .rst_n(rst_n), .t1_mode(t1_mode), .sub_off(sub_off),
        .pos_in(pos_in), .neg_in(neg_in),
        .c_pulse(c_pulse), .c_viol(c_viol), .c_cv(c_cv), .c_exz(c_exz), .c_dual(c_dual),
        .tail(tail)
    );

    bpd_outstage u_out (
        .clk(clk), .rst_n(rst_n), .nrz_mode(nrz_mode), .fall_edge(fall_edge),
        .t_raw_p(tail.raw_p), .t_raw_n(tail.raw_n), .t_mark(tail.mark), .t_err(tail.err),
        .pos_out(pos_out), .neg_out(neg_out)
    );

endmodule

// File: tb/bpd_line_decoder_tb.sv
`timescale 1ns/1ps
module bpd_line_decoder_tb;
    localparam int CLK_T = 8;
    localparam int LAT   = 9;

    typedef struct {
        logic  ep;
        logic  en;
        int    due;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_in = 1'b0, neg_in = 1'b0;
    logic t1_mode = 1'b0, sub_off = 1'b0, nrz_mode = 1'b1, fall_edge = 1'b0;
    logic pos_out, neg_out;

    int n_run = 0;
    int n_fail = 0;
    int cnt = 0;
    item_t sb[$];
    item_t last_it;
    int last_due = -1;

    bpd_line_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .neg_in(neg_in),
        .t1_mode(t1_mode), .sub_off(sub_off), .nrz_mode(nrz_mode), .fall_edge(fall_edge),
        .pos_out(pos_out), .neg_out(neg_out)
    );

    always #(CLK_T/2) clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    task automatic chk(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: outputs act=%b exp=%b at cycle %0d", req, act, exp, cnt);
        end
    endtask

    // Driver: one bit per falling edge; the expected item is due LAT edges later.
    task automatic put(input logic p, input logic n, input logic ep, input logic en, input string req);
        @(negedge clk);
        pos_in = p;
        neg_in = n;
        sb.push_back('{ep, en, cnt + LAT, req});
    endtask

    task automatic cfg(input logic t1, input logic off, input logic nrz, input logic fe);
        @(negedge clk);
        rst_n = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
        t1_mode = t1; sub_off = off; nrz_mode = nrz; fall_edge = fe;
        repeat (3) @(negedge clk);
        chk(pos_out == 1'b0 && neg_out == 1'b0, "R1", {pos_out, neg_out}, 2'b00);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        @(negedge clk);
        pos_in = 1'b0; neg_in = 1'b0;
        repeat (14) @(negedge clk);
    endtask

    // Monitor: compare at a quarter period after the due edge, probe before the next edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_T/4);
            while (sb.size() > 0 && sb[0].due < cnt) begin
                item_t m;
                m = sb.pop_front();
                chk(1'b0, {m.req, " missed"}, {pos_out, neg_out}, {m.ep, m.en});
            end
            if (sb.size() > 0 && sb[0].due == cnt) begin
                last_it = sb.pop_front();
                last_due = cnt;
                chk({pos_out, neg_out} == {last_it.ep, last_it.en}, last_it.req,
                    {pos_out, neg_out}, {last_it.ep, last_it.en});
            end
            #(5*CLK_T/8);
            if (fall_edge && sb.size() > 0 && sb[0].due == cnt + 1)
                chk({pos_out, neg_out} == {sb[0].ep, sb[0].en}, "R3 early",
                    {pos_out, neg_out}, {sb[0].ep, sb[0].en});
            if (!fall_edge && last_due == cnt)
                chk({pos_out, neg_out} == {last_it.ep, last_it.en}, "R2 hold",
                    {pos_out, neg_out}, {last_it.ep, last_it.en});
        end
    end

    initial begin
        #(CLK_T * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // E1 HDB3, NRZ, rising edge (R1 R2 R5 R6 R7 R9 R10 R11)
        cfg(1'b0, 1'b0, 1'b1, 1'b0);
        put(1,0, 1,0, "R1 first pulse");
        put(0,1, 1,0, "R5");
        put(1,0, 1,0, "R5");
        put(0,0, 0,0, "R6"); put(0,0, 0,0, "R6"); put(0,0, 0,0, "R6");
        put(1,0, 0,0, "R6 000V");
        put(0,1, 1,0, "R5");
        put(0,0, 0,0, "R6"); put(0,0, 0,0, "R6"); put(0,0, 0,0, "R6");
        put(0,1, 0,0, "R6 000V");
        put(1,0, 1,0, "R5");
        put(0,0, 0,0, "R6"); put(0,0, 0,0, "R6"); put(0,0, 0,0, "R6");
        put(1,0, 0,0, "R6 000V");
        put(0,1, 1,0, "R5");
        put(1,0, 1,0, "R5");
        put(0,1, 0,0, "R6 B cleared");
        put(0,0, 0,0, "R6"); put(0,0, 0,0, "R6");
        put(0,1, 0,0, "R6 B00V");
        put(1,0, 1,0, "R5");
        put(1,0, 1,1, "R9 bipolar violation");
        put(0,1, 1,0, "R5");
        put(0,0, 0,0, "R11"); put(0,0, 0,0, "R11"); put(0,0, 0,0, "R11");
        put(0,0, 0,1, "R11 fourth zero");
        put(0,1, 0,0, "R6 after run");
        put(1,0, 0,0, "R6 B cleared");
        put(0,0, 0,0, "R6"); put(0,0, 0,0, "R6");
        put(1,0, 0,0, "R6 B00V");
        put(0,1, 1,0, "R5");
        put(1,0, 0,0, "R7 B cleared");
        put(0,0, 0,0, "R7"); put(0,0, 0,0, "R7");
        put(1,0, 0,1, "R7 code violation");
        put(0,1, 1,0, "R5");
        put(1,1, 1,1, "R10 dual rail");
        drain();

        // E1 HDB3, bipolar pass-through (R4)
        cfg(1'b0, 1'b0, 1'b0, 1'b0);
        put(1,0, 1,0, "R4"); put(0,1, 0,1, "R4");
        put(0,0, 0,0, "R4"); put(0,0, 0,0, "R4"); put(0,0, 0,0, "R4");
        put(0,1, 0,1, "R4 substitution raw");
        put(1,0, 1,0, "R4"); put(1,0, 1,0, "R4 violation raw");
        put(1,1, 1,1, "R4 dual raw");
        drain();

        // T1 B8ZS, NRZ (R8 R9 R11)
        cfg(1'b1, 1'b0, 1'b1, 1'b0);
        put(1,0, 1,0, "R5"); put(0,1, 1,0, "R5");
        put(0,0, 0,0, "R8"); put(0,0, 0,0, "R8"); put(0,0, 0,0, "R8");
        put(0,1, 0,0, "R8 V"); put(1,0, 0,0, "R8 B"); put(0,0, 0,0, "R8");
        put(1,0, 0,0, "R8 V"); put(0,1, 0,0, "R8 B");
        put(1,0, 1,0, "R5");
        put(1,0, 1,1, "R9 T1 violation");
        put(0,0, 0,0, "R11 four zeros in T1"); put(0,0, 0,0, "R11");
        put(0,0, 0,0, "R11"); put(0,0, 0,0, "R11 four zeros in T1");
        put(0,0, 0,0, "R11"); put(0,0, 0,0, "R11"); put(0,0, 0,0, "R11");
        put(0,0, 0,1, "R11 eighth zero");
        put(0,1, 1,0, "R5");
        put(0,0, 0,0, "R8"); put(0,0, 0,0, "R8"); put(0,0, 0,0, "R8");
        put(0,1, 1,1, "R9 partial pattern");
        put(1,0, 1,0, "R8 partial"); put(0,1, 1,0, "R8 partial");
        drain();

        // E1 AMI (R12 R11)
        cfg(1'b0, 1'b1, 1'b1, 1'b0);
        put(1,0, 1,0, "R12");
        put(0,0, 0,0, "R12"); put(0,0, 0,0, "R12"); put(0,0, 0,0, "R12");
        put(1,0, 1,1, "R12 000V flagged");
        put(0,1, 1,0, "R12");
        put(0,0, 0,0, "R11"); put(0,0, 0,0, "R11"); put(0,0, 0,0, "R11");
        put(0,0, 0,1, "R11 E1 AMI fourth zero");
        put(1,0, 1,0, "R12");
        drain();

        // T1 AMI with a B8ZS-shaped pattern (R12)
        cfg(1'b1, 1'b1, 1'b1, 1'b0);
        put(1,0, 1,0, "R12"); put(0,1, 1,0, "R12");
        put(0,0, 0,0, "R12"); put(0,0, 0,0, "R12"); put(0,0, 0,0, "R12");
        put(0,1, 1,1, "R12 V kept"); put(1,0, 1,0, "R12"); put(0,0, 0,0, "R12");
        put(1,0, 1,1, "R12 V kept"); put(0,1, 1,0, "R12");
        drain();

        // E1 HDB3, falling-edge outputs (R3)
        cfg(1'b0, 1'b0, 1'b1, 1'b1);
        put(1,0, 1,0, "R3"); put(0,1, 1,0, "R3"); put(1,0, 1,0, "R3");
        put(0,0, 0,0, "R3"); put(0,0, 0,0, "R3"); put(0,0, 0,0, "R3");
        put(1,0, 0,0, "R3 000V");
        put(0,1, 1,0, "R3"); put(0,1, 1,1, "R3 violation"); put(1,0, 1,0, "R3");
        drain();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule